// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block runs on the host side of a parallel NOR-style flash. After the host has written a program or erase command sequence, it pulses `start` with the operation type, the bit it expects on status bit 7 (program only) and the address to watch. The block then reads that address over a simple request/valid read port. It keeps reading until status bit 7 shows completion, a timeout is reported, or a poll budget runs out.

While an operation is busy, status bit 7 reads as the complement of its final value. For a program, the final value is the programmed bit. For an erase, the final value is 1. When bit 5 reports that the device exceeded its internal limit, bit 5 and bit 7 may change together. The block therefore takes one more read before it decides.

On success the block takes one more read, because the word in which bit 7 first turns true may still have other bits that are not valid. It stores that full word and pulses `done_pass`. On failure it pulses `done_fail` together with `reset_cmd_req` and holds a code that separates a device-reported timeout from an exhausted poll budget.

Top module: `dpoll_checker`

## Requirements
- R1: While reset is held and after its release, `rd_req`, `done_pass`, `done_fail` and `reset_cmd_req` are 0 and `fail_code` is 0.
- R2: For a program, a read whose bit 7 equals `exp_bit` counts as complete. A read whose bit 7 is the complement of `exp_bit` counts as busy.
- R3: For an erase (`op_is_erase`=1), a read with bit 7 = 1 counts as complete and a read with bit 7 = 0 counts as busy. `exp_bit` is ignored.
- R4: Every read presents on `rd_addr` the `target_addr` captured at start. `rd_req` stays high with a stable address until a cycle in which `rd_valid` is high.
- R5: A busy read with bit 5 = 1 is followed by exactly one recheck read. If the recheck shows completion, the block proceeds as in R7.
- R6: If the recheck still shows busy, the block pulses `done_fail` and `reset_cmd_req`, and `fail_code` becomes 1 (device timeout).
- R7: After a completing read, the block makes one further read of the same address. It then pulses `done_pass`, and `final_data` holds that further word.
- R8: After POLL_MAX consecutive busy reads with bit 5 = 0, the block pulses `done_fail` and `reset_cmd_req`, and `fail_code` becomes 2 (poll limit).
- R9: Each accepted start yields exactly one one-cycle pulse of `done_pass` or `done_fail`, never both, and then `rd_req` is low. A `start` that arrives while a check is running is ignored.
- R10: When the read that reaches the poll limit also shows bit 5 = 1, the recheck of R5 takes priority over the limit failure.
- R11: A read that shows completion on bit 7 and bit 5 = 1 at the same time counts as complete, and no recheck is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion check |
| op_is_erase | input | 1 | 1 = erase, 0 = program |
| exp_bit | input | 1 | Programmed value of status bit 7 (program only) |
| target_addr | input | AW | Address to poll |
| rd_addr | output | AW | Read address to the flash |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_data | input | DW | Read data word |
| rd_valid | input | 1 | Read data valid; completes the request |
| done_pass | output | 1 | One-cycle success pulse |
| done_fail | output | 1 | One-cycle failure pulse |
| fail_code | output | 2 | 0 none, 1 device timeout, 2 poll limit |
| reset_cmd_req | output | 1 | One-cycle request to issue the flash reset command |
| final_data | output | DW | Valid word read after completion |

## Verification
Two decisions can land on the same read. One is a completion on bit 7 arriving together with the bit-5 timeout flag. The other is the bit-5 flag appearing on the very read that exhausts the poll budget. The bench builds both cases by returning words in which the two bits are set together, including a fourth busy read with bit 5 set under a budget of four. It judges them by the pulse that follows and by `fail_code`: the first case must end in `done_pass` after a single extra read, and the second must end in a recheck and then code 1, not code 2.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHECK,
    ST_FETCH
  } dpoll_state_e;

  localparam logic [1:0] CODE_NONE  = 2'd0;
  localparam logic [1:0] CODE_DEV   = 2'd1;
  localparam logic [1:0] CODE_LIMIT = 2'd2;

  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_TOUT = 5;

  // Final value status bit 7 takes when the operation is finished.
  function automatic logic settled_value(input logic is_erase, input logic prog_bit);
    return is_erase ? 1'b1 : prog_bit;
  endfunction

endpackage

// File: rtl/dpoll_eval.sv
module dpoll_eval #(
  parameter int unsigned DW = 16
) (
  input  logic          is_erase,
  input  logic          prog_bit,
  input  logic [DW-1:0] word,
  output logic          complete,
  output logic          tout_flag
);
  import dpoll_pkg::*;

  always_comb begin
    complete  = (word[BIT_DONE] == settled_value(is_erase, prog_bit));
    tout_flag = word[BIT_TOUT];
  end

endmodule

// File: rtl/dpoll_limit.sv
module dpoll_limit #(
  parameter int unsigned POLL_MAX = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_last
);
  localparam int unsigned CW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_MAX - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker #(
  parameter int unsigned AW       = 24,
  parameter int unsigned DW       = 16,
  parameter int unsigned POLL_MAX = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_is_erase,
  input  logic          exp_bit,
  input  logic [AW-1:0] target_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_req,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          done_pass,
  output logic          done_fail,
  output logic [1:0]    fail_code,
  output logic          reset_cmd_req,
  output logic [DW-1:0] final_data
);
  import dpoll_pkg::*;

  dpoll_state_e state_q, state_d;
  logic op_erase_q, prog_bit_q;
  logic [AW-1:0] addr_q;

  // Named internal events.
  logic ev_accept, ev_read, ev_complete, ev_tout, ev_at_last;
  logic ev_pass, ev_fail_dev, ev_fail_lim, ev_busy_poll;

  assign ev_accept = (state_q == ST_IDLE) && start;
  assign ev_read   = rd_req && rd_valid;

  dpoll_eval #(.DW(DW)) u_eval (
    .is_erase  (op_erase_q),
    .prog_bit  (prog_bit_q),
    .word      (rd_data),
    .complete  (ev_complete),
    .tout_flag (ev_tout)
  );

  assign ev_busy_poll = (state_q == ST_POLL) && ev_read && !ev_complete && !ev_tout;

  dpoll_limit #(.POLL_MAX(POLL_MAX)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ev_accept),
    .bump    (ev_busy_poll),
    .at_last (ev_at_last)
  );

  assign ev_pass     = (state_q == ST_FETCH) && ev_read;
  assign ev_fail_dev = (state_q == ST_RECHECK) && ev_read && !ev_complete;
  assign ev_fail_lim = ev_busy_poll && ev_at_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_POLL;
      ST_POLL: begin
        if (ev_read) begin
          if (ev_complete)      state_d = ST_FETCH;
          else if (ev_tout)     state_d = ST_RECHECK;
          else if (ev_at_last)  state_d = ST_IDLE;
        end
      end
      ST_RECHECK: if (ev_read) state_d = ev_complete ? ST_FETCH : ST_IDLE;
      ST_FETCH:   if (ev_read) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_erase_q <= 1'b0;
      prog_bit_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        op_erase_q <= op_is_erase;
        prog_bit_q <= exp_bit;
        addr_q     <= target_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_pass     <= 1'b0;
      done_fail     <= 1'b0;
      reset_cmd_req <= 1'b0;
      fail_code     <= CODE_NONE;
      final_data    <= '0;
    end else begin
      done_pass     <= ev_pass;
      done_fail     <= ev_fail_dev || ev_fail_lim;
      reset_cmd_req <= ev_fail_dev || ev_fail_lim;
      if (ev_accept)        fail_code <= CODE_NONE;
      else if (ev_fail_dev) fail_code <= CODE_DEV;
      else if (ev_fail_lim) fail_code <= CODE_LIMIT;
      if (ev_pass) final_data <= rd_data;
    end
  end

  assign rd_req  = (state_q != ST_IDLE);
  assign rd_addr = addr_q;

endmodule

// File: rtl/dpoll_checker_sva.sv
module dpoll_checker_sva #(
  parameter int unsigned AW       = 24,
  parameter int unsigned DW       = 16,
  parameter int unsigned POLL_MAX = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_accept,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          done_pass,
  input logic          done_fail,
  input logic          reset_cmd_req,
  input logic [1:0]    fail_code,
  input logic [DW-1:0] final_data
);
  localparam int unsigned CW = $clog2(POLL_MAX + 2);

  logic [CW-1:0] reads_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                          reads_seen <= '0;
    else if (ev_accept)                  reads_seen <= '0;
    else if (rd_req && rd_valid && reads_seen != {CW{1'b1}}) reads_seen <= reads_seen + 1'b1;
  end

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pass && done_fail));
  assert_pass_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pass |=> !done_pass && !rd_req);
  assert_fail_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |=> !done_fail && !rd_req);
  assert_fail_requests_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |-> reset_cmd_req && fail_code != 2'd0);
  assert_reset_only_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd_req |-> done_fail);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));
  assert_final_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pass |-> final_data == $past(rd_data) && $past(rd_req && rd_valid));
  assert_limit_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fail && fail_code == 2'd2) |-> reads_seen == CW'(POLL_MAX));

endmodule

bind dpoll_checker dpoll_checker_sva #(.AW(AW), .DW(DW), .POLL_MAX(POLL_MAX)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_accept     (ev_accept),
  .rd_req        (rd_req),
  .rd_valid      (rd_valid),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .done_pass     (done_pass),
  .done_fail     (done_fail),
  .reset_cmd_req (reset_cmd_req),
  .fail_code     (fail_code),
  .final_data    (final_data)
);

// File: tb/dpoll_checker_tb.sv
module dpoll_checker_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int PM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_is_erase = 1'b0, exp_bit = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic [AW-1:0] rd_addr;
  logic rd_req, rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic done_pass, done_fail, reset_cmd_req;
  logic [1:0] fail_code;
  logic [DW-1:0] final_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dpoll_checker #(.AW(AW), .DW(DW), .POLL_MAX(PM)) u_dut (.*);

  typedef struct packed {
    logic erase;
    logic bitv;
    logic [2:0] nrd;
    logic [4:0][15:0] w;
    logic [1:0] res;
  } vec_t;

  // w[0] is the first word returned. res: 0 pass, 1 device timeout, 2 limit.
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b1, 3'd3, {16'h0, 16'h0, 16'h1234, 16'h0080, 16'h0000}, 2'd0}, // R2 program 1
    '{1'b0, 1'b0, 3'd3, {16'h0, 16'h0, 16'hABCD, 16'h0000, 16'h0080}, 2'd0}, // R2 program 0
    '{1'b1, 1'b0, 3'd4, {16'h0, 16'hFFFF, 16'h0080, 16'h0000, 16'h0000}, 2'd0}, // R3 erase
    '{1'b1, 1'b1, 3'd3, {16'h0, 16'h0, 16'h5A5A, 16'h00A0, 16'h0020}, 2'd0}, // R5 recheck ok
    '{1'b0, 1'b1, 3'd2, {16'h0, 16'h0, 16'h0, 16'h0000, 16'h0020}, 2'd1},    // R6 recheck fails
    '{1'b1, 1'b0, 3'd4, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 2'd2},          // R8 limit
    '{1'b1, 1'b0, 3'd5, {16'h0000, 16'h0020, 16'h0, 16'h0, 16'h0}, 2'd1},    // R10 tout on last
    '{1'b0, 1'b0, 3'd2, {16'h0, 16'h0, 16'h0, 16'h7777, 16'h0020}, 2'd0}     // R11 done with tout
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic er, input logic b, input logic [AW-1:0] a);
    op_is_erase = er; exp_bit = b; target_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic serve(input logic [DW-1:0] d, input logic [AW-1:0] a);
    chk(rd_req == 1'b1, "R4 req", rd_req, 1);
    chk(rd_addr == a, "R4 addr", rd_addr, a);
    rd_valid = 1'b1; rd_data = d;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !done_pass && !done_fail && !reset_cmd_req && fail_code == 0,
        "R1 in reset", {rd_req, done_pass, done_fail, reset_cmd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !done_pass && !done_fail && fail_code == 0, "R1 after reset",
        {rd_req, done_pass, done_fail}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = AW'(24'h100 * (i + 1) + 3);
      kick(VEC[i].erase, VEC[i].bitv, a);
      for (int k = 0; k < int'(VEC[i].nrd); k++) begin
        if (k > 0) chk(!done_pass && !done_fail, "R9 early", {done_pass, done_fail}, 0);
        serve(VEC[i].w[k], a);
      end
      if (VEC[i].res == 2'd0) begin
        chk(done_pass && !done_fail, "R7 pass pulse", {done_pass, done_fail}, 2);
        chk(final_data == VEC[i].w[VEC[i].nrd - 1], "R7 word", final_data,
            VEC[i].w[VEC[i].nrd - 1]);
      end else begin
        chk(done_fail && !done_pass && reset_cmd_req, "R6 R8 fail pulse",
            {done_pass, done_fail, reset_cmd_req}, 3);
        chk(fail_code == VEC[i].res, (VEC[i].res == 1) ? "R6 R10 code" : "R8 code",
            fail_code, VEC[i].res);
      end
      @(negedge clk);
      chk(!done_pass && !done_fail && !rd_req, "R9 one cycle",
          {done_pass, done_fail, rd_req}, 0);
    end

    // R4: request held while no data; R9: start while busy ignored; R3 ignores exp_bit.
    kick(1'b1, 1'b0, 24'hABC);
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b1, "R4 held", rd_req, 1);
    kick(1'b0, 1'b1, 24'h555);
    chk(rd_addr == 24'hABC, "R9 busy start", rd_addr, 24'hABC);
    serve(16'h0080, 24'hABC);
    serve(16'h0F0F, 24'hABC);
    chk(done_pass && final_data == 16'h0F0F, "R9 R3 ignored start", final_data, 16'h0F0F);
    @(negedge clk);
    chk(!rd_req, "R9 idle", rd_req, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule